// File: doc/BRIEF.md
# 8-bit ALU with Skip Logic

This block is the combinational arithmetic and logic stage of a small 8-bit accumulator machine. Each cycle it takes the working register W, an operand read from the register file, the current carry bit and a 3-bit bit-position selector. A 4-bit operation code picks one of twelve functions. The block returns an 8-bit result, a three-bit flag vector with a matching write-enable vector, and a skip signal. The sequencer uses skip to discard the next instruction.

Besides the usual bitwise operations, the block also provides:

- one's complement of either operand;
- rotate left and rotate right through carry;
- nibble swap;
- increment-and-skip and decrement-and-skip when the result is zero;
- skip tests on a single selected bit.

Operand fetch, addressing, write-back and decoding are handled outside this block.

Top module: `alu8_core`

## Requirements
- R1: Op code 0 gives W AND F, op code 1 gives W OR F, and op code 2 gives W XOR F.
- R2: Op code 3 gives the bitwise inverse of F, and op code 4 gives the bitwise inverse of W.
- R3: Op code 5 (rotate left) gives {F[6:0], carry-in} with new carry F[7]. Op code 6 (rotate right) gives {carry-in, F[7:1]} with new carry F[0].
- R4: Op code 7 gives {F[3:0], F[7:4]}, and it writes no flag.
- R5: Op code 8 gives F-1 and op code 9 gives F+1, both modulo 256. Skip is asserted exactly when that result is 0x00.
- R6: Op code 10 asserts skip when F[bit_sel] is 0, and op code 11 asserts skip when F[bit_sel] is 1. Both pass F to the result and write no flag.
- R7: Flags and their enables sit at bit 0 for carry, bit 1 for digit carry and bit 2 for zero. Op codes 0-4, 8 and 9 enable only bit 2. Rotates enable only bit 0. The digit-carry enable is never asserted.
- R8: Whenever the zero flag is enabled, its value is 1 if the 8-bit result is 0x00 and 0 otherwise.
- R9: Skip is 0 for every op code other than 8, 9, 10 and 11.
- R10: Op codes 12-15 pass F to the result, enable no flag and assert no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_in | input | 8 | Working register operand |
| f_in | input | 8 | Register-file operand |
| c_in | input | 1 | Current carry flag |
| bit_sel | input | 3 | Bit position for the bit tests |
| op_code | input | 4 | Operation select |
| result | output | 8 | Operation result |
| flags | output | 3 | New flag values: bit 0 C, bit 1 DC, bit 2 Z |
| flags_we | output | 3 | Per-flag write enables, same bit positions |
| skip | output | 1 | Skip the next instruction |

## Verification
The hardest cases to reach are the wrap points of the counting operations. Skip must fire only for F=0xFF on increment and only for F=0x01 on decrement, and uniform random operands hit each of these about once in 256 tries. The stimulus therefore pins these operands directly. It also walks every bit position through both bit tests with a single set bit and a single clear bit. Random traffic over all sixteen op codes, including the unused ones, covers everything else.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND     = 4'd0,
        OP_OR      = 4'd1,
        OP_XOR     = 4'd2,
        OP_NOT_F   = 4'd3,
        OP_NOT_W   = 4'd4,
        OP_ROT_L   = 4'd5,
        OP_ROT_R   = 4'd6,
        OP_SWAP    = 4'd7,
        OP_DEC_SKZ = 4'd8,
        OP_INC_SKZ = 4'd9,
        OP_SKIP_0  = 4'd10,
        OP_SKIP_1  = 4'd11
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } flag_t;

    localparam flag_t WE_NONE = '{z: 1'b0, dc: 1'b0, c: 1'b0};
    localparam flag_t WE_Z    = '{z: 1'b1, dc: 1'b0, c: 1'b0};
    localparam flag_t WE_C    = '{z: 1'b0, dc: 1'b0, c: 1'b1};

    function automatic logic is_bitwise(input alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
               (op == OP_NOT_F) || (op == OP_NOT_W);
    endfunction

endpackage

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] w_val,
    input  logic [WIDTH-1:0] f_val,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] out_val
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] swapped;

    generate
        for (genvar i = 0; i < HALF; i++) begin : g_swap
            assign swapped[i]        = f_val[i + HALF];
            assign swapped[i + HALF] = f_val[i];
        end
    endgenerate

    always_comb begin
        case (op)
            OP_AND:   out_val = w_val & f_val;
            OP_OR:    out_val = w_val | f_val;
            OP_XOR:   out_val = w_val ^ f_val;
            OP_NOT_F: out_val = ~f_val;
            OP_NOT_W: out_val = ~w_val;
            OP_SWAP:  out_val = swapped;
            default:  out_val = f_val;
        endcase
    end
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] f_val,
    input  logic             carry_in,
    input  logic             to_left,
    output logic [WIDTH-1:0] out_val,
    output logic             carry_out
);
    always_comb begin
        if (to_left) begin
            out_val   = {f_val[WIDTH-2:0], carry_in};
            carry_out = f_val[WIDTH-1];
        end else begin
            out_val   = {carry_in, f_val[WIDTH-1:1]};
            carry_out = f_val[0];
        end
    end
endmodule

// File: rtl/alu8_step.sv
module alu8_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] f_val,
    input  logic             count_up,
    output logic [WIDTH-1:0] out_val
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    assign out_val = count_up ? (f_val + ONE) : (f_val - ONE);
endmodule

// File: rtl/alu8_bittest.sv
module alu8_bittest #(
    parameter int WIDTH = 8,
    localparam int SEL_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] f_val,
    input  logic [SEL_W-1:0] sel,
    input  logic             want_set,
    output logic             hit
);
    logic picked;

    assign picked = f_val[sel];
    assign hit    = want_set ? picked : ~picked;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int SEL_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] w_in,
    input  logic [WIDTH-1:0] f_in,
    input  logic             c_in,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic [OP_W-1:0]  op_code,
    output logic [WIDTH-1:0] result,
    output logic [2:0]       flags,
    output logic [2:0]       flags_we,
    output logic             skip
);
    alu_op_e          op;
    logic [WIDTH-1:0] logic_out;
    logic [WIDTH-1:0] rot_out;
    logic [WIDTH-1:0] step_out;
    logic             rot_carry;
    logic             bit_hit;
    flag_t            flag_val;
    flag_t            flag_en;

    assign op = alu_op_e'(op_code);

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .w_val   (w_in),
        .f_val   (f_in),
        .op      (op),
        .out_val (logic_out)
    );

    alu8_rotate #(.WIDTH(WIDTH)) u_rotate (
        .f_val     (f_in),
        .carry_in  (c_in),
        .to_left   (op == OP_ROT_L),
        .out_val   (rot_out),
        .carry_out (rot_carry)
    );

    alu8_step #(.WIDTH(WIDTH)) u_step (
        .f_val    (f_in),
        .count_up (op == OP_INC_SKZ),
        .out_val  (step_out)
    );

    alu8_bittest #(.WIDTH(WIDTH)) u_bittest (
        .f_val    (f_in),
        .sel      (bit_sel),
        .want_set (op == OP_SKIP_1),
        .hit      (bit_hit)
    );

    always_comb begin
        result  = logic_out;
        flag_en = WE_NONE;
        skip    = 1'b0;
        case (op)
            OP_ROT_L, OP_ROT_R: begin
                result  = rot_out;
                flag_en = WE_C;
            end
            OP_DEC_SKZ, OP_INC_SKZ: begin
                result  = step_out;
                flag_en = WE_Z;
                skip    = (step_out == '0);
            end
            OP_SKIP_0, OP_SKIP_1: begin
                skip = bit_hit;
            end
            default: begin
                if (is_bitwise(op)) flag_en = WE_Z;
            end
        endcase
    end

    always_comb begin
        flag_val.c  = (op == OP_ROT_L || op == OP_ROT_R) ? rot_carry : c_in;
        flag_val.dc = 1'b0;
        flag_val.z  = (result == '0);
    end

    assign flags    = flag_val;
    assign flags_we = flag_en;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
    input logic [7:0] w_in,
    input logic [7:0] f_in,
    input logic       c_in,
    input logic [2:0] bit_sel,
    input logic [3:0] op_code,
    input logic [7:0] result,
    input logic [2:0] flags,
    input logic [2:0] flags_we,
    input logic       skip
);
    always_comb begin
        // R8: a written zero flag agrees with the result
        p_zero_match_r8: assert (!flags_we[2] || (flags[2] == (result == 8'h00)));
        // R7: digit carry enable stays low
        p_no_dc_write_r7: assert (!flags_we[1]);
        // R7: rotates touch only carry
        p_rot_carry_only_r7: assert (!(op_code == 4'd5 || op_code == 4'd6) || flags_we == 3'b001);
        // R9: skip only from the four skip operations
        p_skip_source_r9: assert (!skip || (op_code >= 4'd8 && op_code <= 4'd11));
        // R4: swap keeps the population count of F
        p_swap_ones_r4: assert (op_code != 4'd7 || ($countones(result) == $countones(f_in) && flags_we == 3'b000));
        // R5: increment skips exactly at the wrap point
        p_inc_wrap_r5: assert (op_code != 4'd9 || (skip == (f_in == 8'hFF)));
        // R10: unused codes are inert
        p_reserved_r10: assert (op_code < 4'd12 || (!skip && flags_we == 3'b000 && result == f_in));
    end
endmodule

bind alu8_core alu8_core_chk u_chk (
    .w_in     (w_in),
    .f_in     (f_in),
    .c_in     (c_in),
    .bit_sel  (bit_sel),
    .op_code  (op_code),
    .result   (result),
    .flags    (flags),
    .flags_we (flags_we),
    .skip     (skip)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
    logic       clk = 1'b0;
    logic [7:0] w_in = '0;
    logic [7:0] f_in = '0;
    logic       c_in = 1'b0;
    logic [2:0] bit_sel = '0;
    logic [3:0] op_code = '0;
    logic [7:0] result;
    logic [2:0] flags;
    logic [2:0] flags_we;
    logic       skip;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu8_core uut (
        .w_in(w_in), .f_in(f_in), .c_in(c_in), .bit_sel(bit_sel),
        .op_code(op_code), .result(result), .flags(flags),
        .flags_we(flags_we), .skip(skip)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2: return "R1";
            4'd3, 4'd4:       return "R2";
            4'd5, 4'd6:       return "R3";
            4'd7:             return "R4";
            4'd8, 4'd9:       return "R5";
            4'd10, 4'd11:     return "R6";
            default:          return "R10";
        endcase
    endfunction

    function automatic logic [7:0] exp_res(input logic [3:0] op, input logic [7:0] w,
                                           input logic [7:0] f, input logic c);
        case (op)
            4'd0:  return w & f;
            4'd1:  return w | f;
            4'd2:  return w ^ f;
            4'd3:  return ~f;
            4'd4:  return ~w;
            4'd5:  return {f[6:0], c};
            4'd6:  return {c, f[7:1]};
            4'd7:  return {f[3:0], f[7:4]};
            4'd8:  return f - 8'd1;
            4'd9:  return f + 8'd1;
            default: return f;
        endcase
    endfunction

    function automatic logic [2:0] exp_we(input logic [3:0] op);
        if (op <= 4'd4 || op == 4'd8 || op == 4'd9) return 3'b100;
        if (op == 4'd5 || op == 4'd6) return 3'b001;
        return 3'b000;
    endfunction

    function automatic logic exp_skip(input logic [3:0] op, input logic [7:0] f, input logic [2:0] b);
        case (op)
            4'd8:  return f == 8'h01;
            4'd9:  return f == 8'hFF;
            4'd10: return f[b] == 1'b0;
            4'd11: return f[b] == 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h (op %0d w %02h f %02h c %0b sel %0d)",
                     rq, what, act, exp, op_code, w_in, f_in, c_in, bit_sel);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic [7:0] w, input logic [7:0] f,
                          input logic c, input logic [2:0] b);
        logic [7:0] er;
        logic [2:0] ew;
        @(negedge clk);
        op_code = op; w_in = w; f_in = f; c_in = c; bit_sel = b;
        #1;
        er = exp_res(op, w, f, c);
        ew = exp_we(op);
        chk(req_of(op), "result", result, er);
        chk("R7", "flags_we", {5'b0, flags_we}, {5'b0, ew});
        if (ew[2]) chk("R8", "zero flag", {7'b0, flags[2]}, {7'b0, er == 8'h00});
        if (ew[0]) chk("R3", "carry out", {7'b0, flags[0]},
                       {7'b0, (op == 4'd5) ? f[7] : f[0]});
        chk((op >= 4'd8 && op <= 4'd11) ? req_of(op) : "R9", "skip",
            {7'b0, skip}, {7'b0, exp_skip(op, f, b)});
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd4711);
        // reset-state style check: all-zero inputs select AND of zeros
        #1;
        chk("R1", "idle result", result, 8'h00);
        chk("R8", "idle zero flag", {7'b0, flags[2]}, 8'h01);
        // R1 directed
        run_op(4'd0, 8'hF0, 8'h3C, 1'b0, 3'd0);
        run_op(4'd1, 8'hF0, 8'h0F, 1'b0, 3'd0);
        run_op(4'd2, 8'hAA, 8'hAA, 1'b1, 3'd0);
        // R2 directed
        run_op(4'd3, 8'h00, 8'hFF, 1'b0, 3'd0);
        run_op(4'd4, 8'h5A, 8'h00, 1'b0, 3'd0);
        // R3 carry in and out both ways
        run_op(4'd5, 8'h00, 8'h80, 1'b1, 3'd0);
        run_op(4'd6, 8'h00, 8'h01, 1'b1, 3'd0);
        run_op(4'd5, 8'h00, 8'h7F, 1'b0, 3'd0);
        // R4
        run_op(4'd7, 8'h00, 8'h1E, 1'b1, 3'd0);
        // R5 wrap points
        run_op(4'd9, 8'h00, 8'hFF, 1'b0, 3'd0);
        run_op(4'd8, 8'h00, 8'h01, 1'b0, 3'd0);
        run_op(4'd8, 8'h00, 8'h00, 1'b0, 3'd0);
        run_op(4'd9, 8'h00, 8'hFE, 1'b0, 3'd0);
        // R6 every bit position, single set and single clear
        for (int i = 0; i < 8; i++) begin
            run_op(4'd10, 8'h00, 8'h01 << i, 1'b0, 3'(i));
            run_op(4'd11, 8'h00, 8'h01 << i, 1'b0, 3'(i));
            run_op(4'd10, 8'h00, ~(8'h01 << i), 1'b0, 3'(i));
            run_op(4'd11, 8'h00, ~(8'h01 << i), 1'b0, 3'(i));
        end
        // R10 unused codes
        for (int k = 12; k < 16; k++) run_op(4'(k), 8'h33, 8'hC5, 1'b1, 3'd2);
        // random mix over all codes (R1-R10 by op)
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] f;
            f = 8'($urandom);
            if (n % 16 == 0) f = 8'hFF;
            if (n % 16 == 1) f = 8'h01;
            run_op(4'($urandom), 8'($urandom), f, 1'($urandom), 3'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule